// File: doc/BRIEF.md
# Auto and Self Refresh Sequencer

This block keeps a two-bank dynamic memory refreshed. A free-running interval timer decides when refresh is owed. In distributed mode one auto-refresh command is owed per interval. In burst mode a whole set of auto-refreshes is owed once per long interval, and the set is then issued back to back. Owed refreshes are counted, so a refresh that cannot go out at once is never lost. The sequencer asks the main controller for the command pins through `ref_req`. It issues a command only while the controller grants the pins (`ref_gnt`) and reports both banks idle (`banks_idle`). After each auto-refresh it drives exactly the refresh cycle time in no-operation cycles.

The sequencer also enters and leaves self refresh on request. Entry drives the chip-select, row-strobe and column-strobe lines low together with the clock enable. While in self refresh, the clock enable stays low and every other input is ignored. An exit request raises the clock enable and drives no-operation cycles for the refresh cycle time. In burst mode, a full refresh burst then follows at once.

The interval and the no-operation count are computed from the clock period and the timing values, given in picoseconds, and both are rounded up. The states are:

- `S_IDLE`: nothing owed.
- `S_WAIT`: request raised, waiting for the grant and for both banks to be idle.
- `S_AREF`: one auto-refresh command.
- `S_TRC`: no-operation cycles after a refresh.
- `S_SR_ENTER`: the entry command.
- `S_SELF`: clock enable held low.
- `S_SR_EXIT`: no-operation cycles after wake-up.

The transitions are:

- `S_IDLE` to `S_WAIT` when a refresh is owed or self refresh is requested.
- `S_WAIT` to `S_AREF` when the grant and idle inputs are high and a refresh is owed.
- `S_WAIT` to `S_SR_ENTER` when the grant and idle inputs are high, nothing is owed and self refresh is requested.
- `S_WAIT` to `S_IDLE` when the grant and idle inputs are high and nothing is pending.
- `S_AREF` to `S_TRC` always.
- `S_TRC` to `S_AREF` when the count runs out and the burst is unfinished, or to `S_IDLE` when the count runs out and the burst is done.
- `S_SR_ENTER` to `S_SELF` always.
- `S_SELF` to `S_SR_EXIT` on an exit request.
- `S_SR_EXIT` to `S_AREF` (burst mode) or to `S_IDLE` (distributed mode) when the count runs out.

Top module: `refresh_sequencer`

## Requirements
- R1: Distributed interval. With `burst_mode` low, one auto-refresh is owed every REFI = ceil(REFI_PS/CLK_PERIOD_PS) cycles. If grant and idle stay high, the first command appears REFI+2 cycles after reset release and the next ones follow every REFI cycles.
- R2: Pin encoding `{cs_n,ras_n,cas_n,we_n,cke}`:
  - Auto-refresh is `0,0,0,1,1`.
  - No-operation is `0,1,1,1,1`.
  - Self-refresh entry is `0,0,0,1,0`.
  - Self-refresh hold is `1,1,1,1,0`.
- R3: A command is issued only when both `ref_gnt` and `banks_idle` are high, and only when `cke` was high in the previous cycle. While either is low, `ref_req` stays high and the pins show no-operation.
- R4: Owed refreshes accumulate and are never dropped. Once the pins are granted with the banks idle, each owed refresh is issued, and consecutive owed ones are spaced TRC+3 cycles apart.
- R5: After every auto-refresh exactly TRC = ceil(TRC_PS/CLK_PERIOD_PS) no-operation cycles follow.
- R6: When self refresh is requested with the pins granted, the banks idle and no refresh owed, the entry command appears two cycles after the request is seen in `S_IDLE`. Owed refreshes take priority over entry.
- R7: In self refresh, `cke` stays low and the hold pattern is driven. `sr_req`, `ref_gnt`, `banks_idle` and interval expiries have no effect; expiries are not accumulated.
- R8: An `sr_exit` in self refresh raises `cke` in the next cycle and drives TRC no-operation cycles. The interval timer restarts from zero when these cycles end.
- R9: With `burst_mode` high, a set of BURST_LEN auto-refreshes is owed every REFI*BURST_LEN cycles. Its commands are spaced TRC+1 cycles apart.
- R10: With `burst_mode` high, a full burst of BURST_LEN auto-refreshes starts right after the self-refresh exit cycles, with no grant cycle in between.
- R11: `ref_req` is high in every state except `S_IDLE`.
- R12: During and straight after reset the pins show no-operation with `cke` high and `ref_req` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| burst_mode | input | 1 | 1 selects burst refresh, 0 selects distributed refresh |
| banks_idle | input | 1 | Both banks are precharged and idle |
| ref_gnt | input | 1 | Controller has handed the command pins over |
| sr_req | input | 1 | Request to enter self refresh |
| sr_exit | input | 1 | Request to leave self refresh |
| ref_req | output | 1 | Sequencer wants or holds the command pins |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |

## Verification
The commands are due at fixed cycles after their cause:

- An auto-refresh comes two cycles after its interval expires, or one cycle after the edge that samples grant and idle both high.
- Burst members follow each other every TRC+1 cycles.
- Entry comes two cycles after `sr_req` is seen in `S_IDLE`.
- The first forced-burst command comes TRC+1 cycles after the exit cycle.

The bench computes the exact cycle of each command from these rules and queues it. A monitor pops the queue on every command it observes on the falling edge, comparing cycle and kind. Between commands, spot checks sample the pins, `cke` and `ref_req` at cycles chosen so that every register on the path has settled.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_AREF,
        S_TRC,
        S_SR_ENTER,
        S_SELF,
        S_SR_EXIT
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic cke;
    } pin_bundle_t;

    localparam pin_bundle_t PINS_NOP     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b1};
    localparam pin_bundle_t PINS_AREF    = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, cke: 1'b1};
    localparam pin_bundle_t PINS_SR_GO   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, cke: 1'b0};
    localparam pin_bundle_t PINS_SR_HOLD = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b0};

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int width_for(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int REFI_CYC  = 3900,
    parameter int BURST_LEN = 2048,
    parameter int OWE_W     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_mode,
    input  logic hold,
    input  logic consume,
    output logic owed_nz
);
    import rfsh_pkg::*;

    localparam int PER_B = REFI_CYC * BURST_LEN;
    localparam int CW    = width_for(PER_B);
    localparam logic [CW-1:0] LAST_D = CW'(REFI_CYC - 1);
    localparam logic [CW-1:0] LAST_B = CW'(PER_B - 1);
    localparam logic [OWE_W-1:0] OWE_MAX = '1;

    logic [CW-1:0]    count_q;
    logic [CW-1:0]    last_cnt;
    logic             expire;
    logic [OWE_W-1:0] owed_q;

    assign last_cnt = burst_mode ? LAST_B : LAST_D;
    assign expire   = !hold && (count_q >= last_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (hold || expire) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else if (hold) begin
            owed_q <= '0;
        end else if (expire && !consume) begin
            if (owed_q != OWE_MAX) begin
                owed_q <= owed_q + 1'b1;
            end
        end else if (consume && !expire) begin
            if (owed_q != '0) begin
                owed_q <= owed_q - 1'b1;
            end
        end
    end

    assign owed_nz = (owed_q != '0);

endmodule

// File: rtl/rfsh_down_counter.sv
module rfsh_down_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer #(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int REFI_PS       = 15_600_000,
    parameter int TRC_PS        = 70_000,
    parameter int BURST_LEN     = 2048,
    parameter int OWE_W         = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_mode,
    input  logic banks_idle,
    input  logic ref_gnt,
    input  logic sr_req,
    input  logic sr_exit,
    output logic ref_req,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic cke
);
    import rfsh_pkg::*;

    localparam int REFI_CYC = ceil_div(REFI_PS, CLK_PERIOD_PS);
    localparam int TRC_CYC  = ceil_div(TRC_PS, CLK_PERIOD_PS);
    localparam int TW       = width_for(TRC_CYC);
    localparam int BW       = width_for(BURST_LEN);
    localparam logic [TW-1:0] TRC_LOAD   = TW'(TRC_CYC - 1);
    localparam logic [BW-1:0] BURST_LOAD = BW'(BURST_LEN - 1);

    seq_state_e  state_q, state_d;
    pin_bundle_t pins;

    logic owed_nz;
    logic hold;
    logic consume;
    logic trc_zero, trc_load, trc_dec;
    logic burst_zero, burst_load, burst_dec;
    logic [BW-1:0] burst_val;
    logic grant_ok;

    assign grant_ok = ref_gnt && banks_idle;

    // Interval timer and owed-refresh count
    rfsh_interval_timer #(
        .REFI_CYC (REFI_CYC),
        .BURST_LEN(BURST_LEN),
        .OWE_W    (OWE_W)
    ) u_interval (
        .clk       (clk),
        .rst_n     (rst_n),
        .burst_mode(burst_mode),
        .hold      (hold),
        .consume   (consume),
        .owed_nz   (owed_nz)
    );

    // No-operation cycle counter (after refresh and after wake-up)
    rfsh_down_counter #(.W(TW)) u_trc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (trc_load),
        .load_val(TRC_LOAD),
        .dec     (trc_dec),
        .zero    (trc_zero)
    );

    // Remaining refreshes of the current burst
    rfsh_down_counter #(.W(BW)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (burst_load),
        .load_val(burst_val),
        .dec     (burst_dec),
        .zero    (burst_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (owed_nz || sr_req) begin
                    state_d = S_WAIT;
                end
            end
            S_WAIT: begin
                if (grant_ok) begin
                    if (owed_nz) begin
                        state_d = S_AREF;
                    end else if (sr_req) begin
                        state_d = S_SR_ENTER;
                    end else begin
                        state_d = S_IDLE;
                    end
                end
            end
            S_AREF: begin
                state_d = S_TRC;
            end
            S_TRC: begin
                if (trc_zero) begin
                    state_d = burst_zero ? S_IDLE : S_AREF;
                end
            end
            S_SR_ENTER: begin
                state_d = S_SELF;
            end
            S_SELF: begin
                if (sr_exit) begin
                    state_d = S_SR_EXIT;
                end
            end
            S_SR_EXIT: begin
                if (trc_zero) begin
                    state_d = burst_mode ? S_AREF : S_IDLE;
                end
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // Counter control
    assign hold       = (state_q == S_SR_ENTER) || (state_q == S_SELF) || (state_q == S_SR_EXIT);
    assign consume    = (state_q == S_WAIT) && grant_ok && owed_nz;
    assign trc_load   = (state_q == S_AREF) || ((state_q == S_SELF) && sr_exit);
    assign trc_dec    = (state_q == S_TRC) || (state_q == S_SR_EXIT);
    assign burst_load = consume || ((state_q == S_SR_EXIT) && trc_zero && burst_mode);
    assign burst_val  = burst_mode ? BURST_LOAD : '0;
    assign burst_dec  = (state_q == S_TRC) && trc_zero && !burst_zero;

    // Outputs
    always_comb begin
        pins    = PINS_NOP;
        ref_req = 1'b1;
        unique case (state_q)
            S_IDLE: begin
                pins    = PINS_NOP;
                ref_req = 1'b0;
            end
            S_WAIT:     pins = PINS_NOP;
            S_AREF:     pins = PINS_AREF;
            S_TRC:      pins = PINS_NOP;
            S_SR_ENTER: pins = PINS_SR_GO;
            S_SELF:     pins = PINS_SR_HOLD;
            S_SR_EXIT:  pins = PINS_NOP;
            default: begin
                pins    = PINS_NOP;
                ref_req = 1'b0;
            end
        endcase
    end

    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
    assign cke   = pins.cke;

endmodule

// File: rtl/rfsh_sequencer_chk.sv
module rfsh_sequencer_chk #(
    parameter int TRC_CYC = 18
) (
    input logic clk,
    input logic rst_n,
    input logic banks_idle,
    input logic ref_gnt,
    input logic sr_exit,
    input logic ref_req,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic cke
);
    localparam int GW = (TRC_CYC < 2) ? 2 : $clog2(TRC_CYC + 2);
    localparam logic [GW-1:0] GAP_MAX = GW'(TRC_CYC);

    logic aref_cmd, sre_cmd, nop_cmd;
    logic [GW-1:0] gap_q;

    assign aref_cmd = !cs_n && !ras_n && !cas_n && we_n && cke;
    assign sre_cmd  = !cs_n && !ras_n && !cas_n && we_n && !cke;
    assign nop_cmd  = !cs_n && ras_n && cas_n && we_n && cke;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= GAP_MAX;
        end else if (aref_cmd) begin
            gap_q <= '0;
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_AREF_CKE_PREV: assert property (@(posedge clk) disable iff (!rst_n) aref_cmd |-> $past(cke)); // R3
    AST_NOP_AFTER_AREF: assert property (@(posedge clk) disable iff (!rst_n) aref_cmd |=> nop_cmd); // R5
    AST_TRC_GAP: assert property (@(posedge clk) disable iff (!rst_n) aref_cmd |-> (gap_q >= GAP_MAX)); // R5
    AST_SRE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n) sre_cmd |-> $past(banks_idle && ref_gnt)); // R6
    AST_SELF_CKE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!cke && !sr_exit) |=> !cke); // R7
    AST_EXIT_WAKES: assert property (@(posedge clk) disable iff (!rst_n) ($past(!cke) && !cke && sr_exit) |=> cke); // R8
    AST_CMD_OWNS_PINS: assert property (@(posedge clk) disable iff (!rst_n) (aref_cmd || sre_cmd) |-> ref_req); // R11

endmodule

bind refresh_sequencer rfsh_sequencer_chk #(.TRC_CYC(TRC_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .banks_idle(banks_idle),
    .ref_gnt   (ref_gnt),
    .sr_exit   (sr_exit),
    .ref_req   (ref_req),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .cke       (cke)
);

// File: tb/sim_refresh_sequencer.sv
`timescale 1ns/1ps
module sim_refresh_sequencer;

    localparam int K_AREF = 0;
    localparam int K_SRE  = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic burst_mode = 1'b0;
    logic banks_idle = 1'b1;
    logic ref_gnt = 1'b1;
    logic sr_req = 1'b0;
    logic sr_exit = 1'b0;
    logic ref_req, cs_n, ras_n, cas_n, we_n, cke;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        int    kind;
        string tag;
    } exp_t;
    exp_t sb[$];

    // 250 MHz
    always #2 clk = ~clk;

    refresh_sequencer #(
        .CLK_PERIOD_PS(4000),
        .REFI_PS      (200_000),
        .TRC_PS       (30_000),
        .BURST_LEN    (4),
        .OWE_W        (4)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .burst_mode(burst_mode),
        .banks_idle(banks_idle),
        .ref_gnt   (ref_gnt),
        .sr_req    (sr_req),
        .sr_exit   (sr_exit),
        .ref_req   (ref_req),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .cke       (cke)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    task automatic expect_cmd(input int at, input int kind, input string tag);
        exp_t e;
        e.at = at;
        e.kind = kind;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic at_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    function automatic int pin_word();
        return {27'd0, cs_n, ras_n, cas_n, we_n, cke};
    endfunction

    // Monitor: pops the scoreboard on every command seen
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int w;
            w = pin_word();
            if (w == 5'b00011 || w == 5'b00010) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R2 unexpected command", w, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(cyc == e.at, e.tag, cyc, e.at);
                    chk((w == 5'b00011) == (e.kind == K_AREF), e.tag, w,
                        (e.kind == K_AREF) ? 5'b00011 : 5'b00010);
                end
            end else if (!(w == 5'b01111 || w == 5'b11110)) begin
                chk(1'b0, "R2 illegal pin pattern", w, 5'b01111);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pin_word() == 5'b01111, "R12 pins in reset", pin_word(), 5'b01111);
        chk(ref_req == 1'b0, "R12 ref_req in reset", ref_req, 0);
        rst_n = 1'b1;

        // Phase 1: distributed refresh (REFI=50, TRC=8 from 7.5 rounded up)
        expect_cmd(52,  K_AREF, "R1 first refresh");
        expect_cmd(102, K_AREF, "R1 second refresh");
        expect_cmd(261, K_AREF, "R3 refresh after grant");
        expect_cmd(272, K_AREF, "R4 owed refresh 2");
        expect_cmd(283, K_AREF, "R4 owed refresh 3");
        expect_cmd(302, K_AREF, "R1 interval keeps phase");
        expect_cmd(317, K_SRE,  "R6 self refresh entry");
        expect_cmd(561, K_AREF, "R8 timer restart after exit");

        at_cyc(2);
        chk(pin_word() == 5'b01111, "R12 pins after reset", pin_word(), 5'b01111);
        chk(ref_req == 1'b0, "R11 ref_req idle", ref_req, 0);
        at_cyc(51);
        chk(ref_req == 1'b1, "R11 ref_req while waiting", ref_req, 1);
        at_cyc(53);
        chk(pin_word() == 5'b01111, "R5 nop after refresh", pin_word(), 5'b01111);
        at_cyc(60);
        chk(pin_word() == 5'b01111, "R5 last nop cycle", pin_word(), 5'b01111);
        chk(ref_req == 1'b1, "R11 ref_req during nop", ref_req, 1);
        at_cyc(61);
        chk(ref_req == 1'b0, "R5 release after TRC", ref_req, 0);

        at_cyc(140);
        banks_idle = 1'b0;
        at_cyc(200);
        chk(ref_req == 1'b1, "R3 request held while busy", ref_req, 1);
        chk(pin_word() == 5'b01111, "R3 nop while busy", pin_word(), 5'b01111);
        at_cyc(225);
        ref_gnt = 1'b0;
        at_cyc(230);
        banks_idle = 1'b1;
        at_cyc(255);
        chk(pin_word() == 5'b01111, "R3 nop without grant", pin_word(), 5'b01111);
        at_cyc(260);
        ref_gnt = 1'b1;

        at_cyc(315);
        sr_req = 1'b1;
        at_cyc(318);
        chk(cke == 1'b0, "R7 cke low in self refresh", cke, 0);
        at_cyc(340);
        sr_req = 1'b0;
        banks_idle = 1'b0;
        ref_gnt = 1'b0;
        at_cyc(420);
        chk(pin_word() == 5'b11110, "R7 hold pattern", pin_word(), 5'b11110);
        at_cyc(450);
        banks_idle = 1'b1;
        ref_gnt = 1'b1;
        sr_req = 1'b1;
        at_cyc(480);
        chk(cke == 1'b0, "R7 sr_req ignored in self", cke, 0);
        sr_req = 1'b0;
        at_cyc(500);
        sr_exit = 1'b1;
        at_cyc(501);
        sr_exit = 1'b0;
        chk(pin_word() == 5'b01111, "R8 wake with nop", pin_word(), 5'b01111);
        at_cyc(508);
        chk(pin_word() == 5'b01111, "R8 last exit nop", pin_word(), 5'b01111);
        at_cyc(575);
        chk(sb.size() == 0, "R1 phase 1 all commands seen", sb.size(), 0);

        // Phase 2: burst refresh (burst of 4, interval 200)
        rst_n = 1'b0;
        burst_mode = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        expect_cmd(202, K_AREF, "R9 burst member 1");
        expect_cmd(211, K_AREF, "R9 burst member 2");
        expect_cmd(220, K_AREF, "R9 burst member 3");
        expect_cmd(229, K_AREF, "R9 burst member 4");
        expect_cmd(242, K_SRE,  "R6 entry in burst mode");
        expect_cmd(269, K_AREF, "R10 forced burst 1");
        expect_cmd(278, K_AREF, "R10 forced burst 2");
        expect_cmd(287, K_AREF, "R10 forced burst 3");
        expect_cmd(296, K_AREF, "R10 forced burst 4");
        expect_cmd(471, K_AREF, "R9 burst interval after exit");

        at_cyc(100);
        chk(ref_req == 1'b0, "R9 no refresh before long interval", ref_req, 0);
        at_cyc(240);
        sr_req = 1'b1;
        at_cyc(244);
        sr_req = 1'b0;
        at_cyc(260);
        sr_exit = 1'b1;
        at_cyc(261);
        sr_exit = 1'b0;
        chk(cke == 1'b1, "R8 cke high after exit", cke, 1);
        at_cyc(480);
        chk(sb.size() == 0, "R10 phase 2 all commands seen", sb.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule